// File: doc/BRIEF.md
# Port-Size Transfer Splitter with Lane Steering

This block sits between an internal requester and an external data port whose width is chosen at run time: 8, 16 or 32 bits. It accepts a single internal transfer of one byte, a halfword, a word or a 16-byte line. It then issues that transfer as a sequence of port-sized beats. For each beat it presents the byte address and places the data on the proper byte lanes of a 32-bit bus. It raises the lane enables and marks whether the beat belongs to a burst. Each beat is held until the far side acknowledges it.

On reads, the bytes returned in each beat are gathered back into the internal data word. A one-cycle completion pulse follows the last acknowledged beat. A narrow port can sit on the upper lanes of the bus or be shifted onto the lower lanes.

Oversized transfers run either as one burst or as independent single beats. This is chosen separately for reads and for writes. A further mode bit chooses whether lane enables are shown on reads as well as on writes. All configuration is captured when a request is accepted.

Top module: `port_splitter`

## Requirements
- R1: Size codes are 00 byte, 01 halfword, 10 word and 11 line (16 bytes). Port codes are 00 for 32-bit, 01 for 8-bit, and 10 or 11 for 16-bit. A transfer issues max(1, transfer bytes / port bytes) beats, and beat_valid is low once the last beat is acknowledged.
- R2: Each beat carries min(transfer bytes, port bytes) bytes. Beat i has address req_addr + i * beat bytes, so addresses ascend from the request address.
- R3: Transfer byte j is req_wdata[WD_W-1-8j -: 8] and is the byte at request address + j. Bus byte slot p (p = 0 is bits 31:24, p = 3 is bits 7:0) is driven with the beat's byte whose address satisfies (address mod port bytes) = p - base. The base is 0 with lane_shift low. With lane_shift high it is 4 - port bytes. All other slots, and every slot on reads, are zero.
- R4: A 32-bit port always uses slot base 0, whatever the state of lane_shift.
- R5: beat_burst is 1 on every beat of a transfer that has more than one beat when the enable for its direction is set (burst_wr_en for writes, burst_rd_en for reads). Otherwise it is 0. The enable of the other direction has no effect.
- R6: beat_be bit 3-p is high for each slot p that the beat occupies. It is driven on writes always, and on reads only when be_mode is 1; otherwise it is 0.
- R7: On a read, done_rdata holds returned bus slot p of beat i at transfer byte i*beat_bytes + p - base - (start address mod port bytes). Layout is as in R3, and unused bytes are 0.
- R8: A beat's outputs stay unchanged until beat_ack. done pulses for exactly one cycle, in the cycle after the last beat's acknowledge. req_ready is low while a transfer runs, and a request raised then is ignored.
- R9: beat_last is high only on the final beat of a transfer.
- R10: After reset, req_ready is 1 and beat_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Ready for a request (idle) |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | ADDR_W | Start byte address, aligned to the size |
| req_wdata | input | WD_W | Write data, left-justified |
| port_size | input | 2 | External port width code |
| lane_shift | input | 1 | Move a narrow port to the low lanes |
| burst_rd_en | input | 1 | Run oversized reads as one burst |
| burst_wr_en | input | 1 | Run oversized writes as one burst |
| be_mode | input | 1 | Show lane enables on reads too |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_burst | output | 1 | Beat belongs to a burst |
| beat_last | output | 1 | Final beat of the transfer |
| beat_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| beat_wdata | output | 32 | Lane-placed write data |
| beat_ack | input | 1 | Beat acknowledge |
| beat_rdata | input | 32 | Returned read bus |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | WD_W | Gathered read data |

## Verification
The first beat appears in the cycle after the edge that accepts the request. Every later beat appears in the cycle after the edge that took the previous acknowledge. done and the gathered read word are due in the cycle after the edge of the last acknowledge, and done is gone one cycle later.

The bench drives all inputs on the falling edge and samples on the falling edge, so every check lands in the cycle where its result is due. It sweeps every size, port code, lane shift, enable pair, lane-enable mode and aligned sub-word offset. Acknowledges are sometimes delayed a cycle to check that beats hold. Requests raised mid-transfer check that they are ignored.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int BUS_BYTES = 4;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_LINE = 2'd3} xfer_size_e;

  // log2 of transfer bytes
  function automatic logic [2:0] size_log2(input logic [1:0] sz, input logic [2:0] line_log);
    case (sz)
      SZ_BYTE: return 3'd0;
      SZ_HALF: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return line_log;
    endcase
  endfunction

  // log2 of port bytes: 00 -> 32-bit, 01 -> 8-bit, 1x -> 16-bit
  function automatic logic [2:0] port_log2(input logic [1:0] ps);
    case (ps)
      2'b00:   return 3'd2;
      2'b01:   return 3'd0;
      default: return 3'd1;
    endcase
  endfunction

  // first bus byte slot used by a beat (slot 0 = bits 31:24)
  function automatic logic [1:0] lane_pos(input logic [2:0] plog, input logic shift,
                                          input logic [1:0] alo);
    logic [2:0] pw, base, offs;
    pw   = 3'd1 << plog;
    base = (shift && plog != 3'd2) ? (3'd4 - pw) : 3'd0;
    offs = {1'b0, alo} & (pw - 3'd1);
    return 2'(base + offs);
  endfunction

  function automatic logic in_window(input logic [2:0] bs, input logic [1:0] pos, input int p);
    return (p >= int'(pos)) && (p < int'(pos) + (1 << bs));
  endfunction

  // transfer byte index carried by bus slot p of beat idx
  function automatic int byte_slot(input logic [7:0] idx, input logic [2:0] bs,
                                   input logic [1:0] pos, input int p);
    return (int'(idx) << bs) + p - int'(pos);
  endfunction

endpackage

// File: rtl/beat_seq.sv
module beat_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  input  logic [2:0]       nb_log,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             done
);
  localparam int CW = IDX_W + 1;

  logic [CW-1:0] nxt, lim;
  logic          step_ev, end_ev;

  assign nxt     = {1'b0, idx} + CW'(1);
  assign lim     = CW'(1) << nb_log;
  assign last    = busy && (nxt == lim);
  assign step_ev = busy && ack && !last;
  assign end_ev  = busy && ack && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= end_ev;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (end_ev) begin
        busy <= 1'b0;
      end else if (step_ev) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R8: an unacknowledged beat holds its index
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> busy && $stable(idx));
  // R8: completion pulse follows the last acknowledge
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> done && !busy);
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: beats advance one at a time
  p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> idx == $past(idx) + IDX_W'(1));
endmodule

// File: rtl/lane_steer.sv
module lane_steer import spl_pkg::*; #(
  parameter int WD_W  = 128,
  parameter int IDX_W = 4
) (
  input  logic [WD_W-1:0]        wdata,
  input  logic [IDX_W-1:0]       idx,
  input  logic [2:0]             bs_log,
  input  logic [1:0]             pos,
  input  logic                   valid,
  input  logic                   wr,
  input  logic                   drive_be,
  output logic [8*BUS_BYTES-1:0] bus_wdata,
  output logic [BUS_BYTES-1:0]   be
);
  logic [7:0] idx8;
  assign idx8 = 8'(idx);

  for (genvar p = 0; p < BUS_BYTES; p++) begin : g_lane
    logic            win;
    logic [WD_W-1:0] moved;
    always_comb begin
      win   = in_window(bs_log, pos, p);
      moved = wdata << (8 * (win ? byte_slot(idx8, bs_log, pos, p) : 0));
    end
    assign bus_wdata[8*(BUS_BYTES-1-p) +: 8] = (win && wr) ? moved[WD_W-1 -: 8] : 8'h00;
    assign be[BUS_BYTES-1-p] = win && valid && drive_be;
  end
endmodule

// File: rtl/read_gather.sv
module read_gather import spl_pkg::*; #(
  parameter int WD_W  = 128,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   capture,
  input  logic [8*BUS_BYTES-1:0] rbus,
  input  logic [IDX_W-1:0]       idx,
  input  logic [2:0]             bs_log,
  input  logic [1:0]             pos,
  output logic [WD_W-1:0]        rdata
);
  logic [WD_W-1:0] ins;
  logic [7:0]      idx8;
  assign idx8 = 8'(idx);

  always_comb begin
    ins = '0;
    for (int p = 0; p < BUS_BYTES; p++) begin
      if (in_window(bs_log, pos, p))
        ins = ins | ({rbus[8*(BUS_BYTES-1-p) +: 8], {(WD_W-8){1'b0}}}
                     >> (8 * byte_slot(idx8, bs_log, pos, p)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (clear)   rdata <= '0;
    else if (capture) rdata <= rdata | ins;
  end
endmodule

// File: rtl/port_splitter.sv
module port_splitter import spl_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LOG = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [1:0]                          req_size,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [8*(1<<LINE_LOG)-1:0]          req_wdata,
  input  logic [1:0]                          port_size,
  input  logic                                lane_shift,
  input  logic                                burst_rd_en,
  input  logic                                burst_wr_en,
  input  logic                                be_mode,
  output logic                                beat_valid,
  output logic [ADDR_W-1:0]                   beat_addr,
  output logic                                beat_burst,
  output logic                                beat_last,
  output logic [3:0]                          beat_be,
  output logic [31:0]                         beat_wdata,
  input  logic                                beat_ack,
  input  logic [31:0]                         beat_rdata,
  output logic                                done,
  output logic [8*(1<<LINE_LOG)-1:0]          done_rdata
);
  localparam int LINE_BYTES = 1 << LINE_LOG;
  localparam int WD_W       = 8 * LINE_BYTES;
  localparam int IDX_W      = LINE_LOG;

  // request decode
  logic       start, busy;
  logic [2:0] tlog_d, plog_d, bs_d, nb_d;
  logic       burst_d;

  assign start   = req_valid && req_ready;
  assign tlog_d  = size_log2(req_size, 3'(LINE_LOG));
  assign plog_d  = port_log2(port_size);
  assign bs_d    = (tlog_d < plog_d) ? tlog_d : plog_d;
  assign nb_d    = tlog_d - bs_d;
  assign burst_d = (nb_d != 3'd0) && (req_write ? burst_wr_en : burst_rd_en);

  // captured request
  logic [ADDR_W-1:0] addr_q;
  logic [WD_W-1:0]   wd_q;
  logic              write_q, burst_q, bem_q, shift_q;
  logic [2:0]        plog_q, bs_q, nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; wd_q <= '0; write_q <= 1'b0; burst_q <= 1'b0;
      bem_q <= 1'b0; shift_q <= 1'b0; plog_q <= 3'd2; bs_q <= '0; nb_q <= '0;
    end else if (start) begin
      addr_q <= req_addr; wd_q <= req_wdata; write_q <= req_write; burst_q <= burst_d;
      bem_q <= be_mode; shift_q <= lane_shift; plog_q <= plog_d; bs_q <= bs_d; nb_q <= nb_d;
    end
  end

  logic [IDX_W-1:0] idx;
  logic [1:0]       pos;

  beat_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(beat_ack), .nb_log(nb_q),
    .busy(busy), .idx(idx), .last(beat_last), .done(done)
  );

  assign req_ready  = !busy;
  assign beat_valid = busy;
  assign beat_burst = busy && burst_q;
  assign beat_addr  = addr_q + (ADDR_W'(idx) << bs_q);
  assign pos        = lane_pos(plog_q, shift_q, beat_addr[1:0]);

  lane_steer #(.WD_W(WD_W), .IDX_W(IDX_W)) u_steer (
    .wdata(wd_q), .idx(idx), .bs_log(bs_q), .pos(pos), .valid(busy), .wr(write_q),
    .drive_be(write_q || bem_q), .bus_wdata(beat_wdata), .be(beat_be)
  );

  read_gather #(.WD_W(WD_W), .IDX_W(IDX_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .clear(start), .capture(busy && beat_ack && !write_q),
    .rbus(beat_rdata), .idx(idx), .bs_log(bs_q), .pos(pos), .rdata(done_rdata)
  );

  logic [31:0] be_mask;
  for (genvar b = 0; b < 4; b++) begin : g_mask
    assign be_mask[8*b +: 8] = {8{beat_be[b]}};
  end

  // R2: consecutive beats step by the beat size
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ack && !beat_last |=>
      (beat_addr - $past(beat_addr)) == (ADDR_W'(1) << bs_q));
  // R5: burst marker constant across a transfer
  p_burst_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ack && !beat_last |=> $stable(beat_burst));
  // R6: enabled lanes match the beat size or are all off
  p_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_be == 4'd0) || ($countones(beat_be) == (1 << bs_q)));
  // R3: write data only on enabled lanes
  p_wdata_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && write_q |-> (beat_wdata & ~be_mask) == 32'd0);
  // R9: last beat only while a beat is presented
  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
endmodule

// File: tb/sim_port_splitter.sv
module sim_port_splitter;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int WD_W   = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd0, port_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WD_W-1:0] req_wdata = '0;
  logic lane_shift = 1'b0, burst_rd_en = 1'b0, burst_wr_en = 1'b0, be_mode = 1'b0;
  logic beat_ack = 1'b0;
  logic [31:0] beat_rdata = '0;
  logic req_ready, beat_valid, beat_burst, beat_last, done;
  logic [ADDR_W-1:0] beat_addr;
  logic [3:0] beat_be;
  logic [31:0] beat_wdata;
  logic [WD_W-1:0] done_rdata;

  int checks = 0;
  int errors = 0;
  int n_xfer = 0;

  always #(CLK_P/2) clk = ~clk;

  port_splitter #(.ADDR_W(ADDR_W), .LINE_LOG(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .port_size(port_size), .lane_shift(lane_shift), .burst_rd_en(burst_rd_en),
    .burst_wr_en(burst_wr_en), .be_mode(be_mode), .beat_valid(beat_valid),
    .beat_addr(beat_addr), .beat_burst(beat_burst), .beat_last(beat_last),
    .beat_be(beat_be), .beat_wdata(beat_wdata), .beat_ack(beat_ack),
    .beat_rdata(beat_rdata), .done(done), .done_rdata(done_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [WD_W-1:0] act,
                     input logic [WD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (xfer %0d): actual %h expected %h", tag, n_xfer, act, exp);
    end
  endtask

  task automatic run_xfer(input int wr, input int sz, input int ps, input int sh,
                          input int brd, input int bwr, input int bem, input int alo);
    int tl, pl, bsl, bs, nb, pw, base_slot;
    bit gap, intrude, eburst;
    logic [31:0] base;
    logic [WD_W-1:0] wd, exp_rd;
    tl  = (sz == 3) ? 4 : sz;
    case (ps)
      0: pl = 2;
      1: pl = 0;
      default: pl = 1;
    endcase
    bsl = (tl < pl) ? tl : pl;
    bs  = 1 << bsl;
    nb  = 1 << (tl - bsl);
    pw  = 1 << pl;
    base_slot = (sh != 0 && pw < 4) ? 4 - pw : 0;
    base = 32'h0004_0000 + 32'(n_xfer * 32) + 32'(alo);
    wd = {$urandom(), $urandom(), $urandom(), $urandom()};
    exp_rd = '0;
    gap     = (n_xfer % 3 == 0);
    intrude = gap && (n_xfer % 7 == 0);
    eburst  = (nb > 1) && ((wr != 0) ? (bwr != 0) : (brd != 0));

    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready when idle", WD_W'(req_ready), 1);
    req_write = wr[0]; req_size = sz[1:0]; port_size = ps[1:0]; lane_shift = sh[0];
    burst_rd_en = brd[0]; burst_wr_en = bwr[0]; be_mode = bem[0];
    req_addr = base; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    for (int i = 0; i < nb; i++) begin
      logic [31:0] a, ewd, rpat;
      logic [3:0] ebe;
      int pos;
      a   = base + 32'(i * bs);
      pos = base_slot + (int'(a[1:0]) % pw);
      ebe = '0;
      ewd = '0;
      rpat = $urandom();
      for (int p = 0; p < 4; p++) begin
        if (p >= pos && p < pos + bs) begin
          int j;
          j = i * bs + p - pos;
          if (wr != 0 || bem != 0) ebe[3-p] = 1'b1;
          if (wr != 0) ewd[31-8*p -: 8] = wd[WD_W-1-8*j -: 8];
          exp_rd[WD_W-1-8*j -: 8] = rpat[31-8*p -: 8];
        end
      end
      if (gap && (i % 2 == 0)) begin
        if (intrude && i == 0) begin
          req_valid = 1'b1;
          req_addr  = 32'hFFFF_0000;
        end
        chk(beat_valid == 1'b1 && beat_addr == a, "R8 beat held without ack",
            WD_W'(beat_addr), WD_W'(a));
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = base;
        chk(beat_addr == a, "R8 beat still held after wait", WD_W'(beat_addr), WD_W'(a));
      end
      chk(beat_valid == 1'b1, "R1 beat presented", WD_W'(beat_valid), 1);
      chk(beat_addr == a, "R2 beat address", WD_W'(beat_addr), WD_W'(a));
      chk(beat_burst == eburst, "R5 burst marker", WD_W'(beat_burst), WD_W'(eburst));
      chk(beat_last == (i == nb - 1), "R9 last marker", WD_W'(beat_last), WD_W'(i == nb - 1));
      chk(beat_be == ebe, "R6 lane enables", WD_W'(beat_be), WD_W'(ebe));
      if (ps == 0)
        chk(beat_wdata == ewd, "R4 full-width lanes", WD_W'(beat_wdata), WD_W'(ewd));
      else
        chk(beat_wdata == ewd, "R3 lane placement", WD_W'(beat_wdata), WD_W'(ewd));
      beat_rdata = rpat;
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end

    chk(done == 1'b1, "R8 done after last ack", WD_W'(done), 1);
    chk(beat_valid == 1'b0, "R1 no beat after count", WD_W'(beat_valid), 0);
    if (wr == 0)
      chk(done_rdata == exp_rd, "R7 gathered read data", done_rdata, exp_rd);
    @(negedge clk);
    chk(done == 1'b0 && beat_valid == 1'b0, "R8 single pulse, busy request ignored",
        WD_W'({done, beat_valid}), 0);
    n_xfer++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", WD_W'(req_ready), 1);
    chk(beat_valid == 1'b0, "R10 reset no beat", WD_W'(beat_valid), 0);
    chk(done == 1'b0, "R10 reset no done", WD_W'(done), 0);

    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 4; sz++)
        for (int ps = 0; ps < 4; ps++)
          for (int sh = 0; sh < 2; sh++)
            for (int en = 0; en < 4; en++)
              for (int bem = 0; bem < 2; bem++) begin
                int nofs;
                nofs = (sz == 0) ? 4 : ((sz == 1) ? 2 : 1);
                for (int k = 0; k < nofs; k++)
                  run_xfer(wr, sz, ps, sh, en & 1, (en >> 1) & 1, bem, k << sz);
              end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule